// File: doc/BRIEF.md
# Switch-Driven Power Button Pulse Controller

This block decides when an attached module gets power and when it receives a press on its power button. It watches a main-supply-present level and a debounced on/off toggle switch. It drives a held power-enable output and a timed button pulse. The module starts by itself once powered. For that reason the first switch-on, or the supply arriving while the switch is already on, only turns power on and presses nothing. After that, every flip of the switch, in either direction, presses the button once.

All three inputs pass through a two-stage synchronizer. A switch flip is found by comparing the synchronized level with its value one cycle earlier. A state machine holds the enabled condition, which acts like a set/reset latch. An enabling event sets it and loss of supply clears it. One shared down-counter times two things: a short inhibit window after enabling, and the button pulse. Both lengths come from a clock-frequency parameter. The module's off-status input is passed through, synchronized, as a status output only.

States: `ST_IDLE` (supply absent or just back), `ST_ARMED` (supply present, switch off, never enabled), `ST_INHIBIT` (just enabled, pulses blocked), `ST_READY` (enabled, waiting for a flip), `ST_PULSE` (button pressed). Transitions:
- any state → `ST_IDLE` on supply loss.
- IDLE→INHIBIT when the supply arrives with the switch on.
- IDLE→ARMED when the supply arrives with the switch off.
- ARMED→INHIBIT on switch-on.
- INHIBIT→READY when the timer expires.
- READY→PULSE on a switch flip.
- PULSE→READY when the timer expires.

Top module: `switch_pulse_ctrl`

## Requirements
- R1: While the supply is present and the block has not been enabled since the supply came up, a switch held off keeps `enable_o` and `button_o` low.
- R2: A switch off-to-on change while the supply is present and the block is not enabled raises `enable_o` on the third rising clock edge after the input change, and produces no button pulse.
- R3: If the supply appears while the switch is already on, `enable_o` rises and no button pulse is produced.
- R4: Once raised, `enable_o` stays high for as long as the synchronized supply stays present. Switch position and `module_off_in` do not affect it.
- R5: While enabled and idle, each switch change in either direction produces exactly one `button_o` pulse. `button_o` is never high while `enable_o` is low.
- R6: A button pulse lasts exactly PULSE_CYC = (CLK_HZ/1000)·PULSE_MS clock cycles, unless the supply is lost first.
- R7: For INHIB_CYC = (CLK_HZ/1000)·INHIBIT_MS cycles after `enable_o` rises, no pulse can start. A switch change in that window is dropped and not remembered.
- R8: If `supply_in` is low for three consecutive clock edges, `enable_o` and `button_o` are low after those edges. Any running pulse is cut short. The next supply arrival starts again from the not-enabled condition.
- R9: A switch change during a running pulse is ignored. It neither queues a second pulse nor restarts the pulse timer.
- R10: `module_off_o` equals `module_off_in` delayed by two clock edges and changes nothing else.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| supply_in | input | 1 | Main supply present (high = present) |
| switch_in | input | 1 | Debounced toggle switch (high = on) |
| module_off_in | input | 1 | Off-status reported by the module |
| enable_o | output | 1 | Module power enable |
| button_o | output | 1 | Power button pulse to the module |
| module_off_o | output | 1 | Synchronized copy of `module_off_in` |

## Verification
Two functions can collide in the same cycle: the pulse timer is still running, or the inhibit window is still open, when a new switch change is detected. A flip made a few cycles after switch-on lands inside the inhibit window. A flip made a few hundred cycles into a pulse lands inside the pulse. Random flip spacings, chosen either well inside or well outside the running pulse, are scored by a bench model that tracks the remaining busy time. The pass criteria are the exact pulse count and an exact pulse width for every pulse.

// File: rtl/spc_pkg.sv
package spc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_ARMED   = 3'd1,
        ST_INHIBIT = 3'd2,
        ST_READY   = 3'd3,
        ST_PULSE   = 3'd4
    } spc_state_e;

endpackage

// File: rtl/spc_sync.sv
// Two-stage level synchronizer, one chain per bit.
module spc_sync #(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_in,
    output logic [WIDTH-1:0] q_out
);

    for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic stage1_q;
        logic stage2_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage1_q <= 1'b0;
                stage2_q <= 1'b0;
            end else begin
                stage1_q <= d_in[b];
                stage2_q <= stage1_q;
            end
        end

        assign q_out[b] = stage2_q;
    end

endmodule

// File: rtl/spc_toggle.sv
// Flags any change of a synchronized level against its previous-cycle value.
module spc_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic changed
);

    logic level_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) level_d <= 1'b0;
        else        level_d <= level;
    end

    assign changed = level ^ level_d;

endmodule

// File: rtl/spc_timer.sv
// Loadable down-counter; expired while the count sits at zero.
module spc_timer #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    output logic             expired
);

    logic [WIDTH-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             cnt_q <= '0;
        else if (load)          cnt_q <= load_val;
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/switch_pulse_ctrl.sv
module switch_pulse_ctrl
    import spc_pkg::*;
#(
    parameter int CLK_HZ     = 1_000_000,
    parameter int PULSE_MS   = 100,
    parameter int INHIBIT_MS = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_in,
    input  logic switch_in,
    input  logic module_off_in,
    output logic enable_o,
    output logic button_o,
    output logic module_off_o
);

    localparam int TICKS_PER_MS = CLK_HZ / 1000;
    localparam int PULSE_CYC    = TICKS_PER_MS * PULSE_MS;
    localparam int INHIB_CYC    = TICKS_PER_MS * INHIBIT_MS;
    localparam int LONGEST      = (PULSE_CYC > INHIB_CYC) ? PULSE_CYC : INHIB_CYC;
    localparam int TMR_W        = $clog2(LONGEST + 1) + 1;

    localparam logic [TMR_W-1:0] PULSE_LOAD = TMR_W'(PULSE_CYC - 1);
    localparam logic [TMR_W-1:0] INHIB_LOAD = TMR_W'(INHIB_CYC - 1);

    // synchronized inputs: [0] supply, [1] switch, [2] module off
    logic [2:0] sync_q;
    logic       sup_s;
    logic       sw_s;
    logic       sw_toggle;

    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_done;

    spc_state_e state_q;
    spc_state_e state_d;

    spc_sync #(.WIDTH(3)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  ({module_off_in, switch_in, supply_in}),
        .q_out (sync_q)
    );

    assign sup_s        = sync_q[0];
    assign sw_s         = sync_q[1];
    assign module_off_o = sync_q[2];

    spc_toggle u_tog (
        .clk     (clk),
        .rst_n   (rst_n),
        .level   (sw_s),
        .changed (sw_toggle)
    );

    spc_timer #(.WIDTH(TMR_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state and timer loads
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        if (!sup_s) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (sw_s) begin
                        state_d  = ST_INHIBIT;
                        tmr_load = 1'b1;
                        tmr_val  = INHIB_LOAD;
                    end else begin
                        state_d  = ST_ARMED;
                    end
                end
                ST_ARMED: begin
                    if (sw_s) begin
                        state_d  = ST_INHIBIT;
                        tmr_load = 1'b1;
                        tmr_val  = INHIB_LOAD;
                    end
                end
                ST_INHIBIT: begin
                    if (tmr_done) state_d = ST_READY;
                end
                ST_READY: begin
                    if (sw_toggle) begin
                        state_d  = ST_PULSE;
                        tmr_load = 1'b1;
                        tmr_val  = PULSE_LOAD;
                    end
                end
                ST_PULSE: begin
                    if (tmr_done) state_d = ST_READY;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // outputs decoded from the state register
    always_comb begin
        enable_o = 1'b0;
        button_o = 1'b0;
        unique case (state_q)
            ST_INHIBIT, ST_READY: enable_o = 1'b1;
            ST_PULSE: begin
                enable_o = 1'b1;
                button_o = 1'b1;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/spc_checker.sv
module spc_checker #(
    parameter int PULSE_CYC = 2,
    parameter int INHIB_CYC = 1
) (
    input logic clk,
    input logic rst_n,
    input logic supply_in,
    input logic module_off_in,
    input logic enable_o,
    input logic button_o,
    input logic module_off_o,
    input logic sup_s,
    input logic sw_s
);

    localparam int RW = $clog2(PULSE_CYC + 1) + 2;
    localparam int EW = $clog2(INHIB_CYC + 1) + 2;

    logic [1:0]    age_q;
    logic [RW-1:0] run_len;
    logic [EW-1:0] en_age;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              age_q <= '0;
        else if (age_q != 2'd3)  age_q <= age_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                         run_len <= '0;
        else if (!button_o)                 run_len <= '0;
        else if (run_len <= RW'(PULSE_CYC)) run_len <= run_len + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          en_age <= '0;
        else if (!enable_o)                  en_age <= '0;
        else if (en_age < EW'(INHIB_CYC))    en_age <= en_age + 1'b1;
    end

    p_btn_in_enable_r5: assert property (@(posedge clk) disable iff (!rst_n)
        button_o |-> enable_o);

    p_btn_from_flip_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3 && $rose(button_o)) |-> ($past(sw_s) != $past(sw_s, 2)));

    p_width_max_r6: assert property (@(posedge clk) disable iff (!rst_n)
        button_o |-> (run_len < RW'(PULSE_CYC)));

    p_width_exact_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!button_o && run_len != '0 && sup_s) |-> (run_len == RW'(PULSE_CYC)));

    p_inhibit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q != 2'd0 && $rose(button_o)) |-> (en_age == EW'(INHIB_CYC)));

    p_enable_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q != 2'd0 && $rose(enable_o)) |-> !button_o);

    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q != 2'd0 && $fell(enable_o)) |-> !sup_s);

    p_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3 && !supply_in && !$past(supply_in) && !$past(supply_in, 2))
        |=> (!enable_o && !button_o));

    p_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3) |-> (module_off_o == $past(module_off_in, 2)));

endmodule

bind switch_pulse_ctrl spc_checker #(
    .PULSE_CYC (PULSE_CYC),
    .INHIB_CYC (INHIB_CYC)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .supply_in     (supply_in),
    .module_off_in (module_off_in),
    .enable_o      (enable_o),
    .button_o      (button_o),
    .module_off_o  (module_off_o),
    .sup_s         (sup_s),
    .sw_s          (sw_s)
);

// File: tb/switch_pulse_ctrl_tb.sv
`timescale 1ns/1ps
module switch_pulse_ctrl_tb;

    localparam int CLK_HZ     = 20_000;
    localparam int PULSE_MS   = 100;
    localparam int INHIBIT_MS = 1;
    localparam int PULSE_CYC  = (CLK_HZ / 1000) * PULSE_MS;
    localparam int INHIB_CYC  = (CLK_HZ / 1000) * INHIBIT_MS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_in = 1'b0;
    logic switch_in = 1'b0;
    logic module_off_in = 1'b0;
    logic enable_o, button_o, module_off_o;

    int checks = 0;
    int errors = 0;
    int pulse_cnt = 0;
    int high_len = 0;
    int last_w = 0;
    int bad_w = 0;
    logic btn_prev = 1'b0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    switch_pulse_ctrl #(
        .CLK_HZ(CLK_HZ), .PULSE_MS(PULSE_MS), .INHIBIT_MS(INHIBIT_MS)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .supply_in(supply_in), .switch_in(switch_in),
        .module_off_in(module_off_in), .enable_o(enable_o), .button_o(button_o),
        .module_off_o(module_off_o)
    );

    // pulse monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (button_o && !btn_prev) begin
            pulse_cnt = pulse_cnt + 1;
            high_len  = 0;
        end
        if (button_o) high_len = high_len + 1;
        if (!button_o && btn_prev) begin
            last_w = high_len;
            if (supply_in && high_len != PULSE_CYC) bad_w = bad_w + 1;
        end
        btn_prev = button_o;
    end

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // chooses a gap well clear of the moment the running pulse ends
    function automatic int pick_gap(input int busy, input int r);
        int g;
        g = (r[0]) ? (40 + (r % 400)) : (PULSE_CYC + 20 + (r % 300));
        if ((busy - g) > -12 && (busy - g) < 12) g = g + 30;
        return g;
    endfunction

    initial begin
        repeat (190_000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int base;
        int exp_p;
        int busy;
        int r;
        void'($urandom(32'h0000_5A17));

        // reset state
        wait_cyc(3);
        check("R1 reset enable", int'(enable_o), 0);
        check("R1 reset button", int'(button_o), 0);
        rst_n = 1'b1;

        // supply on, switch off: nothing happens
        supply_in = 1'b1;
        wait_cyc(30);
        check("R1 armed enable", int'(enable_o), 0);
        check("R1 armed button", int'(button_o), 0);

        // first switch-on: enable on third edge, no pulse
        base = pulse_cnt;
        switch_in = 1'b1;
        wait_cyc(2);
        check("R2 enable before latency", int'(enable_o), 0);
        wait_cyc(1);
        check("R2 enable at latency", int'(enable_o), 1);
        wait_cyc(50);
        check("R2 no pulse on first on", pulse_cnt - base, 0);

        // on-to-off flip fires one pulse of exact width
        base = pulse_cnt;
        switch_in = 1'b0;
        wait_cyc(PULSE_CYC + 20);
        check("R5 off flip pulse count", pulse_cnt - base, 1);
        check("R6 pulse width", last_w, PULSE_CYC);
        check("R4 enable held", int'(enable_o), 1);

        // flip during a pulse is ignored, timer not restarted
        base = pulse_cnt;
        switch_in = 1'b1;
        wait_cyc(300);
        switch_in = 1'b0;
        wait_cyc(PULSE_CYC + 50);
        check("R9 one pulse only", pulse_cnt - base, 1);
        check("R9 width not restarted", last_w, PULSE_CYC);

        // module status passes through, affects nothing
        base = pulse_cnt;
        module_off_in = 1'b1;
        wait_cyc(2);
        check("R10 status follows", int'(module_off_o), 1);
        wait_cyc(50);
        module_off_in = 1'b0;
        wait_cyc(50);
        check("R10 status no pulse", pulse_cnt - base, 0);
        check("R4 enable with status", int'(enable_o), 1);

        // random flip spacing against a busy-time model
        base = pulse_cnt;
        exp_p = 0;
        busy = 0;
        bad_w = 0;
        for (int i = 0; i < 24; i++) begin
            switch_in = ~switch_in;
            if (busy <= 0) begin
                exp_p++;
                busy = PULSE_CYC;
            end
            r = int'($urandom & 32'h7FFF_FFFF);
            r = pick_gap(busy, r);
            wait_cyc(r);
            busy = busy - r;
        end
        wait_cyc(PULSE_CYC + 50);
        check("R5 R9 random pulse count", pulse_cnt - base, exp_p);
        check("R6 random widths", bad_w, 0);
        check("R4 enable after random", int'(enable_o), 1);

        // supply loss mid pulse
        switch_in = ~switch_in;
        wait_cyc(100);
        check("R5 pulse running", int'(button_o), 1);
        supply_in = 1'b0;
        wait_cyc(3);
        check("R8 enable cleared", int'(enable_o), 0);
        check("R8 button cut", int'(button_o), 0);

        // supply returns with switch already on
        switch_in = 1'b1;
        wait_cyc(10);
        base = pulse_cnt;
        supply_in = 1'b1;
        wait_cyc(30);
        check("R3 enable on supply", int'(enable_o), 1);
        check("R3 no pulse on supply", pulse_cnt - base, 0);

        // loss, then return with switch off: not enabled
        supply_in = 1'b0;
        switch_in = 1'b0;
        wait_cyc(10);
        supply_in = 1'b1;
        wait_cyc(30);
        check("R8 latch cleared", int'(enable_o), 0);

        // flip inside inhibit window is dropped
        base = pulse_cnt;
        switch_in = 1'b1;
        wait_cyc(6);
        switch_in = 1'b0;
        wait_cyc(INHIB_CYC + 100);
        check("R7 inhibit drop", pulse_cnt - base, 0);
        check("R7 enable kept", int'(enable_o), 1);
        switch_in = 1'b1;
        wait_cyc(PULSE_CYC + 20);
        check("R7 pulse after window", pulse_cnt - base, 1);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule